// File: doc/BRIEF.md
# General-Purpose I/O Port with Open-Drain Emulation

This block is one 16-pin general-purpose digital I/O port. Four registers sit behind a simple register bus: a direction register, an output data latch, an open-drain select register and a pin-level view. For each pin the port drives a pad data bit and an active-high pad output enable. It also brings the pad input levels back in through a synchronizer, so software can read the real pin levels rather than what the latch holds.

A peripheral crossbar can take over any single pin. When its per-pin override flag is set, the crossbar's data and enable replace the latch and direction bit for that pin. Open-drain emulation still applies to that pin. The register contents stay as they were.

Every write carries a per-bit mask. Writing the pin-level register stores a merge into the latch: masked-in bits come from the write data, and masked-out bits come from the synchronized pin levels. This is the classic read-modify-write-on-pins behaviour. Writing the latch register instead keeps the old latch bits wherever the mask is clear.

Top module: `gpio_port_top`

## Requirements
- R1: After reset, every direction bit is 1 (input), and the latch, the open-drain bits and the read data are 0. No pad output enable is asserted.
- R2: With open-drain off and no override, a pin whose direction bit is 0 has its pad output enable asserted and its pad data equal to its latch bit. Pad data follows the latch on every pin without open-drain.
- R3: A pin with open-drain bit 1 has pad data 0. Its output enable is asserted only when the pin is an output and its effective data bit is 0.
- R4: An open-drain bit has no effect on a pin whose direction bit is 1 and which has no override: that pin's output enable stays 0.
- R5: Reading the latch register (address 2) returns the latch contents, even when the pin levels differ.
- R6: Reading the pin register (address 1) returns the pad inputs through a two-stage synchronizer. A level applied before clock edge e appears in a read captured at edge e+2 and not in one captured at edge e+1.
- R7: A write to the pin register (address 1) loads the latch. Bits with mask 1 take the write data. Bits with mask 0 take the synchronized pin level.
- R8: Writes to the direction (address 0), latch (address 2) and open-drain (address 3) registers change only the bits whose mask bit is 1.
- R9: A set crossbar override flag replaces the latch bit with the override data and the direction with the override enable for that pin. No register changes except through a bus write.
- R10: Open-drain emulation applies to overridden pins. Override data 1 on an open-drain pin releases the pin (enable 0). Override data 0 pulls it low.
- R11: Read data is registered. It updates on the edge that captures a read request and holds its value on every other cycle, including write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 direction, 1 pins, 2 latch, 3 open-drain |
| bus_wdata | input | 16 | Write data |
| bus_wmask | input | 16 | Per-bit write enable |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 16 | Pad input levels (asynchronous) |
| pad_out | output | 16 | Pad output data |
| pad_oe | output | 16 | Pad output enable, active high |
| xbar_ovr_en | input | 16 | Per-pin crossbar override flag |
| xbar_ovr_out | input | 16 | Crossbar override data |
| xbar_ovr_oe | input | 16 | Crossbar override output enable |

## Verification
The output former is exercised with mixed input and output directions over a latch pattern that has both levels in each nibble. It is then exercised again with open-drain switched on for every pin. Comparing the two runs separates push-pull driving, open-drain pull-low and the input-pin case. A loopback pad model drives the external levels against the latch contents, so latch reads and pin reads must disagree. The same model applies a level step between back-to-back pin reads, which pins the synchronizer depth to exactly two stages. Masked writes go to the pin register and to the latch register while the external pin and the latch hold opposite values, so merging from pins cannot be confused with merging from the latch. Override patterns are applied with the register state set against them, and on open-drain pins, and then the registers are read back.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 2'd0,
    REG_PINS = 2'd1,
    REG_LAT  = 2'd2,
    REG_ODC  = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_sel,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [WIDTH-1:0]  acc_wdata,
  input  logic [WIDTH-1:0]  acc_wmask,
  input  logic [WIDTH-1:0]  pin_lvl,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  lat_q,
  output logic [WIDTH-1:0]  odc_q,
  output logic [WIDTH-1:0]  rdata_q
);
  logic [WIDTH-1:0] new_bits;
  logic [WIDTH-1:0] rd_mux;
  logic             wr_go;
  logic             rd_go;
  gpio_reg_e        sel_reg;

  assign sel_reg  = gpio_reg_e'(acc_addr);
  assign new_bits = acc_wdata & acc_wmask;
  assign wr_go    = acc_sel & acc_wr;
  assign rd_go    = acc_sel & ~acc_wr;

  always_comb begin
    unique case (sel_reg)
      REG_DIR:  rd_mux = dir_q;
      REG_PINS: rd_mux = pin_lvl;
      REG_LAT:  rd_mux = lat_q;
      REG_ODC:  rd_mux = odc_q;
      default:  rd_mux = '0;
    endcase
  end

  // Direction register: reset to all inputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
    end else if (wr_go && sel_reg == REG_DIR) begin
      dir_q <= new_bits | (dir_q & ~acc_wmask);
    end
  end

  // Latch: the pin-register path merges from pin levels, the latch path from itself.
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
    end else if (wr_go && sel_reg == REG_PINS) begin
      lat_q <= new_bits | (pin_lvl & ~acc_wmask);
    end else if (wr_go && sel_reg == REG_LAT) begin
      lat_q <= new_bits | (lat_q & ~acc_wmask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      odc_q <= '0;
    end else if (wr_go && sel_reg == REG_ODC) begin
      odc_q <= new_bits | (odc_q & ~acc_wmask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_go) begin
      rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_port_drive.sv
module gpio_port_drive #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] odc_q,
  input  logic [WIDTH-1:0] ovr_en,
  input  logic [WIDTH-1:0] ovr_out,
  input  logic [WIDTH-1:0] ovr_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic eff_data;
    logic eff_drive;

    always_comb begin
      eff_data  = ovr_en[i] ? ovr_out[i] : lat_q[i];
      eff_drive = ovr_en[i] ? ovr_oe[i]  : ~dir_q[i];
      if (odc_q[i]) begin
        // Emulated open drain: only ever pull low.
        pad_out[i] = 1'b0;
        pad_oe[i]  = eff_drive & ~eff_data;
      end else begin
        pad_out[i] = eff_data;
        pad_oe[i]  = eff_drive;
      end
    end
  end
endmodule

// File: rtl/gpio_port_top.sv
module gpio_port_top
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  bus_wmask,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [WIDTH-1:0]  xbar_ovr_en,
  input  logic [WIDTH-1:0]  xbar_ovr_out,
  input  logic [WIDTH-1:0]  xbar_ovr_oe
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] odc_q;

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .acc_sel   (bus_sel),
    .acc_wr    (bus_wr),
    .acc_addr  (bus_addr),
    .acc_wdata (bus_wdata),
    .acc_wmask (bus_wmask),
    .pin_lvl   (pin_sync),
    .dir_q     (dir_q),
    .lat_q     (lat_q),
    .odc_q     (odc_q),
    .rdata_q   (bus_rdata)
  );

  gpio_port_drive #(.WIDTH(WIDTH)) drive_i (
    .dir_q   (dir_q),
    .lat_q   (lat_q),
    .odc_q   (odc_q),
    .ovr_en  (xbar_ovr_en),
    .ovr_out (xbar_ovr_out),
    .ovr_oe  (xbar_ovr_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pad_in,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  xbar_ovr_en,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  lat_q,
  input logic [WIDTH-1:0]  odc_q
);
  localparam int HIST = SYNC_STAGES + 1;

  logic [WIDTH-1:0] pin_hist [HIST];
  logic [3:0]       run_cnt;

  always_ff @(posedge clk) begin
    pin_hist[0] <= pad_in;
    for (int k = 1; k < HIST; k++) pin_hist[k] <= pin_hist[k-1];
  end

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (run_cnt != 4'hF) run_cnt <= run_cnt + 4'd1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (dir_q == '1 && lat_q == '0 && odc_q == '0 && bus_rdata == '0 && pad_oe == '0));

  assert_od_pull_low_only_R3: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & odc_q & ~xbar_ovr_en & lat_q) == '0) && ((pad_out & odc_q) == '0));

  assert_input_never_driven_R4: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & dir_q & ~xbar_ovr_en) == '0);

  assert_pin_read_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == REG_PINS && run_cnt > 4'(HIST))
    |=> bus_rdata == pin_hist[HIST-1]);

  assert_regs_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr) |=> ($stable(dir_q) && $stable(lat_q) && $stable(odc_q)));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind gpio_port_top gpio_port_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .pad_in      (pad_in),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .xbar_ovr_en (xbar_ovr_en),
  .dir_q       (dir_q),
  .lat_q       (lat_q),
  .odc_q       (odc_q)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_top_tb_top;
  localparam int W = 16;
  localparam logic [1:0] A_DIR = 2'd0, A_PINS = 2'd1, A_LAT = 2'd2, A_ODC = 2'd3;

  logic         clk = 1'b0;
  logic         rst;
  logic         bus_sel, bus_wr;
  logic [1:0]   bus_addr;
  logic [W-1:0] bus_wdata, bus_wmask, bus_rdata;
  logic [W-1:0] pad_in, pad_out, pad_oe;
  logic [W-1:0] ext_lvl;
  logic [W-1:0] ovr_en, ovr_out, ovr_oe;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  // Pad model: a driven pin reads back its own data, otherwise the external level.
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_lvl);

  gpio_port_top dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .xbar_ovr_en(ovr_en), .xbar_ovr_out(ovr_out), .xbar_ovr_oe(ovr_oe)
  );

  task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; bus_wmask = '0; ext_lvl = '0;
    ovr_en = '0; ovr_out = '0; ovr_oe = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input logic [W-1:0] m);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wmask = m;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    do_reset();
    check("R1", "pad_oe", pad_oe, '0);
    check("R1", "rdata", bus_rdata, '0);
    rd(A_DIR, v); check("R1", "dir", v, 16'hFFFF);
    rd(A_LAT, v); check("R1", "latch", v, 16'h0000);
    rd(A_ODC, v); check("R1", "odc", v, 16'h0000);
  endtask

  task automatic t_push_pull_and_od();
    logic [W-1:0] v;
    do_reset();
    ext_lvl = 16'hFFFF;
    wr(A_LAT, 16'hA5C3, 16'hFFFF);
    wr(A_DIR, 16'hFF00, 16'hFFFF);
    check("R2", "pad_oe", pad_oe, 16'h00FF);
    check("R2", "pad_out", pad_out, 16'hA5C3);
    wr(A_ODC, 16'hFFFF, 16'hFFFF);
    check("R3", "od pad_out", pad_out, 16'h0000);
    check("R3", "od pad_oe low byte", pad_oe & 16'h00FF, 16'h003C);
    check("R4", "od on inputs pad_oe", pad_oe & 16'hFF00, 16'h0000);
    repeat (3) @(negedge clk);
    rd(A_PINS, v); check("R3", "od pin levels", v, 16'hFFC3);
  endtask

  task automatic t_latch_vs_pin();
    logic [W-1:0] v;
    do_reset();
    wr(A_LAT, 16'h1234, 16'hFFFF);
    ext_lvl = 16'hF0F0;
    repeat (3) @(negedge clk);
    rd(A_LAT, v);  check("R5", "latch read", v, 16'h1234);
    rd(A_PINS, v); check("R6", "pin read", v, 16'hF0F0);
  endtask

  task automatic t_sync_latency();
    logic [W-1:0] v0, v1, v2;
    do_reset();
    repeat (3) @(negedge clk);
    ext_lvl = 16'hBEEF;
    rd(A_PINS, v0);
    rd(A_PINS, v1);
    rd(A_PINS, v2);
    check("R6", "read at edge e", v0, 16'h0000);
    check("R6", "read at edge e+1", v1, 16'h0000);
    check("R6", "read at edge e+2", v2, 16'hBEEF);
  endtask

  task automatic t_masked_writes();
    logic [W-1:0] v;
    do_reset();
    ext_lvl = 16'h0008;
    repeat (3) @(negedge clk);
    wr(A_PINS, 16'h0001, 16'h0001);
    rd(A_LAT, v); check("R7", "pin-register merge", v, 16'h0009);
    ext_lvl = 16'h0000;
    repeat (3) @(negedge clk);
    wr(A_LAT, 16'h0002, 16'h0002);
    rd(A_LAT, v); check("R8", "latch merge keeps latch", v, 16'h000B);
    wr(A_DIR, 16'h0000, 16'h00F0);
    rd(A_DIR, v); check("R8", "dir merge", v, 16'hFF0F);
    wr(A_ODC, 16'hFFFF, 16'h8001);
    rd(A_ODC, v); check("R8", "odc merge", v, 16'h8001);
  endtask

  task automatic t_override();
    logic [W-1:0] v;
    do_reset();
    wr(A_DIR, 16'hFFEF, 16'hFFFF);
    wr(A_LAT, 16'h0010, 16'hFFFF);
    ovr_en = 16'h0013; ovr_out = 16'h0001; ovr_oe = 16'h0003;
    @(negedge clk);
    check("R9", "override pad_oe", pad_oe, 16'h0003);
    check("R9", "override pad_out", pad_out & 16'h0013, 16'h0001);
    rd(A_LAT, v); check("R9", "latch unchanged", v, 16'h0010);
    rd(A_DIR, v); check("R9", "dir unchanged", v, 16'hFFEF);
    wr(A_ODC, 16'h0001, 16'h0001);
    check("R10", "od override release", pad_oe & 16'h0001, 16'h0000);
    check("R10", "od override pad_out", pad_out & 16'h0001, 16'h0000);
    ovr_out = 16'h0000;
    @(negedge clk);
    check("R10", "od override pull low", pad_oe & 16'h0001, 16'h0001);
    ovr_en = '0;
    @(negedge clk);
    check("R9", "override released", pad_oe, 16'h0010);
  endtask

  task automatic t_rdata_hold();
    logic [W-1:0] v;
    do_reset();
    wr(A_LAT, 16'h5A5A, 16'hFFFF);
    rd(A_LAT, v);
    ext_lvl = 16'h1111;
    wr(A_LAT, 16'h0F0F, 16'hFFFF);
    repeat (3) @(negedge clk);
    check("R11", "rdata held", bus_rdata, 16'h5A5A);
  endtask

  initial begin
    rst = 1'b1;
    t_reset();
    t_push_pull_and_od();
    t_latch_vs_pin();
    t_sync_latency();
    t_masked_writes();
    t_override();
    t_rdata_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule